// File: doc/BRIEF.md
# Unlock-Sequence Flash Bank Programmer

This controller erases or programs one bank of a byte-wide parallel flash whose commands are written as unlock cycles to fixed offsets above the bank base. A pulse on `start` latches the operation (`op_prog` low for erase, high for program) and the bank base address. The controller then drives a simple synchronous bus: a write strobe with address and data, and a read strobe whose data comes back one cycle later. Every command write is followed by a programmable idle gap. Completion of each erase or byte program is found by reading the bank base twice in a row: when both reads agree, the device has stopped toggling.

When the device is finished, or the poll limit runs out, the controller writes the reset command to the base. After a clean erase it reads back the whole bank and expects 0xFF in every byte. After a clean program it expects each byte to equal the source byte, which it fetches through `src_addr`/`src_data`. The result appears on `err_code` together with a one-cycle `done` pulse.

States: IDLE waits for start. CMD issues one command write. GAP waits out the write spacing and then either advances to the next command step or enters polling. POLL_A and POLL_B issue the two base reads. POLL_C compares them and moves to the next byte, to RST, or back to POLL_A. RST writes the reset command. RST_GAP waits and then enters verify, or goes straight to FIN after a timeout. VRD issues a verify read. VCMP compares it and moves on or stops. FIN pulses done and returns to IDLE.

Top module: `flash_bank_prog`

## Requirements
- R1: Every erase, and every byte program, opens with two unlock writes: 0xAA to base+0x555, then 0x55 to base+0x2AA. All command offsets are added to the `bank_base` value latched at start.
- R2: After the unlock, an erase writes 0x80 to base+0x555, 0xAA to base+0x555, 0x55 to base+0x2AA and 0x30 to base, in that order.
- R3: A program (`op_prog`=1) handles bytes 0 to BANK_BYTES-1 in ascending order. For each byte it writes the unlock, then 0xA0 to base+0x555, then `src_data` for that index to base+index.
- R4: Between any two bus writes there are at least GAP_CYC cycles with `fl_we` low.
- R5: After the last command write of an erase or byte program, the block reads the base in back-to-back pairs. Read data arrives one cycle after `fl_re`. The operation is complete when the two values of a pair are equal.
- R6: If MAX_POLLS consecutive pairs differ, the operation stops: no further byte is programmed and no verify read is made. The reset write follows and `err_code` becomes 1 (timeout). The base therefore sees exactly 2*MAX_POLLS polling reads.
- R7: Once polling finishes, by completion or by timeout, the block writes 0xF0 to base before any verify read. It is the last write of the operation.
- R8: After a completed operation the block reads every byte of the bank. It expects 0xFF after an erase and `src_data` after a program. It stops at the first mismatch with `err_code` 2; if every byte matches, `err_code` is 0.
- R9: `start` is accepted only while idle, and a start pulse while busy has no effect. `done` is a one-cycle pulse. `err_code` holds its value from `done` until the next accepted start.
- R10: `fl_we` and `fl_re` are never high together. After reset the block is idle with both strobes low and `err_code` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, accepted when idle |
| op_prog | input | 1 | 0 = erase bank, 1 = program bank |
| bank_base | input | ADDR_W | Bank base address, latched at start |
| busy | output | 1 | High while an operation runs, including the done cycle |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 2 | 0 ok, 1 poll timeout, 2 verify mismatch |
| fl_addr | output | ADDR_W | Flash bus address |
| fl_wdata | output | 8 | Flash write data |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |
| fl_rdata | input | 8 | Flash read data, valid one cycle after fl_re |
| src_addr | output | IDX_W | Index of the source byte needed |
| src_data | input | 8 | Source byte for src_addr, combinational |

## Verification
The assertions assume several things about the inputs. `start` is a single-cycle pulse. `fl_rdata` answers a read exactly one cycle after the strobe. `src_data` follows `src_addr` within the same cycle. The checks on strobe exclusion, the write spacing, done width and error stability also rely on reset being applied before any start. The bench keeps to these assumptions. Its flash stub registers read data through a one-cycle pipeline, and its source pattern is a pure function of the index. It drives `start` for exactly one clock, and it puts the one deliberate overlapping start in the middle of an operation, where it must be ignored.

// File: rtl/fpg_pkg.sv
package fpg_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CMD,
        S_GAP,
        S_POLL_A,
        S_POLL_B,
        S_POLL_C,
        S_RST,
        S_RST_GAP,
        S_VRD,
        S_VCMP,
        S_FIN
    } fpg_state_t;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_TIMEOUT = 2'd1,
        ERR_VERIFY  = 2'd2
    } fpg_err_t;

    localparam logic [11:0] OFS_KEY_A   = 12'h555;
    localparam logic [11:0] OFS_KEY_B   = 12'h2AA;
    localparam logic [7:0]  CMD_KEY_A   = 8'hAA;
    localparam logic [7:0]  CMD_KEY_B   = 8'h55;
    localparam logic [7:0]  CMD_ERS_ARM = 8'h80;
    localparam logic [7:0]  CMD_ERS_GO  = 8'h30;
    localparam logic [7:0]  CMD_PGM     = 8'hA0;
    localparam logic [7:0]  CMD_RESET   = 8'hF0;
    localparam logic [7:0]  BLANK_BYTE  = 8'hFF;

    localparam logic [2:0]  ERASE_LAST_STEP = 3'd5;
    localparam logic [2:0]  PGM_LAST_STEP   = 3'd3;

endpackage

// File: rtl/fpg_cmd_table.sv
module fpg_cmd_table
    import fpg_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 13
) (
    input  logic              is_prog,
    input  logic [2:0]        step,
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  idx,
    input  logic [7:0]        src_byte,
    output logic [ADDR_W-1:0] addr,
    output logic [7:0]        data,
    output logic              last_step
);

    logic [ADDR_W-1:0] ofs;

    always_comb begin
        ofs  = '0;
        data = CMD_KEY_A;
        if (is_prog) begin
            unique case (step)
                3'd0: begin ofs = ADDR_W'(OFS_KEY_A); data = CMD_KEY_A; end
                3'd1: begin ofs = ADDR_W'(OFS_KEY_B); data = CMD_KEY_B; end
                3'd2: begin ofs = ADDR_W'(OFS_KEY_A); data = CMD_PGM;   end
                default: begin ofs = ADDR_W'(idx);   data = src_byte;  end
            endcase
        end else begin
            unique case (step)
                3'd0: begin ofs = ADDR_W'(OFS_KEY_A); data = CMD_KEY_A;   end
                3'd1: begin ofs = ADDR_W'(OFS_KEY_B); data = CMD_KEY_B;   end
                3'd2: begin ofs = ADDR_W'(OFS_KEY_A); data = CMD_ERS_ARM; end
                3'd3: begin ofs = ADDR_W'(OFS_KEY_A); data = CMD_KEY_A;   end
                3'd4: begin ofs = ADDR_W'(OFS_KEY_B); data = CMD_KEY_B;   end
                default: begin ofs = '0;              data = CMD_ERS_GO;  end
            endcase
        end
        addr      = base + ofs;
        last_step = is_prog ? (step == PGM_LAST_STEP) : (step == ERASE_LAST_STEP);
    end

endmodule

// File: rtl/fpg_gap_timer.sv
module fpg_gap_timer #(
    parameter int GAP_CYC = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);

    localparam int CW = $clog2(GAP_CYC + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CW'(GAP_CYC);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/fpg_poll_limit.sv
module fpg_poll_limit #(
    parameter int MAX_POLLS = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);

    localparam int CW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign at_limit = (cnt_q == CW'(MAX_POLLS - 1));

endmodule

// File: rtl/flash_bank_prog.sv
module flash_bank_prog
    import fpg_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int BANK_BYTES = 8192,
    parameter int GAP_CYC    = 125,
    parameter int MAX_POLLS  = 1000000,
    localparam int IDX_W     = $clog2(BANK_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_prog,
    input  logic [ADDR_W-1:0] bank_base,
    output logic              busy,
    output logic              done,
    output logic [1:0]        err_code,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [7:0]        fl_wdata,
    output logic              fl_we,
    output logic              fl_re,
    input  logic [7:0]        fl_rdata,
    output logic [IDX_W-1:0]  src_addr,
    input  logic [7:0]        src_data
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BANK_BYTES - 1);

    fpg_state_t        state_q, state_d;
    logic              prog_q;
    logic [ADDR_W-1:0] base_q;
    logic [2:0]        step_q;
    logic [IDX_W-1:0]  idx_q;
    logic [7:0]        first_q;
    fpg_err_t          err_q;

    // strobes from the next-state logic to the datapath
    logic take_start, step_inc, step_clr, idx_inc, idx_clr;
    logic set_tmo, set_vfy, poll_clr, poll_inc, tmr_load;

    logic [ADDR_W-1:0] tbl_addr;
    logic [7:0]        tbl_data;
    logic              tbl_last;
    logic              tmr_done;
    logic              poll_hit;
    logic [7:0]        expect_byte;

    fpg_cmd_table #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_tbl (
        .is_prog   (prog_q),
        .step      (step_q),
        .base      (base_q),
        .idx       (idx_q),
        .src_byte  (src_data),
        .addr      (tbl_addr),
        .data      (tbl_data),
        .last_step (tbl_last)
    );

    fpg_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .expired (tmr_done)
    );

    fpg_poll_limit #(.MAX_POLLS(MAX_POLLS)) u_poll (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (poll_clr),
        .inc      (poll_inc),
        .at_limit (poll_hit)
    );

    assign expect_byte = prog_q ? src_data : BLANK_BYTE;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state and datapath strobes
    always_comb begin
        state_d    = state_q;
        take_start = 1'b0;
        step_inc   = 1'b0;
        step_clr   = 1'b0;
        idx_inc    = 1'b0;
        idx_clr    = 1'b0;
        set_tmo    = 1'b0;
        set_vfy    = 1'b0;
        poll_clr   = 1'b0;
        poll_inc   = 1'b0;
        tmr_load   = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    take_start = 1'b1;
                    poll_clr   = 1'b1;
                    state_d    = S_CMD;
                end
            end
            S_CMD: begin
                tmr_load = 1'b1;
                state_d  = S_GAP;
            end
            S_GAP: begin
                if (tmr_done) begin
                    if (tbl_last) begin
                        state_d = S_POLL_A;
                    end else begin
                        step_inc = 1'b1;
                        state_d  = S_CMD;
                    end
                end
            end
            S_POLL_A: state_d = S_POLL_B;
            S_POLL_B: state_d = S_POLL_C;
            S_POLL_C: begin
                if (first_q == fl_rdata) begin
                    if (prog_q && (idx_q != LAST_IDX)) begin
                        idx_inc  = 1'b1;
                        step_clr = 1'b1;
                        poll_clr = 1'b1;
                        state_d  = S_CMD;
                    end else begin
                        state_d = S_RST;
                    end
                end else if (poll_hit) begin
                    set_tmo = 1'b1;
                    state_d = S_RST;
                end else begin
                    poll_inc = 1'b1;
                    state_d  = S_POLL_A;
                end
            end
            S_RST: begin
                tmr_load = 1'b1;
                state_d  = S_RST_GAP;
            end
            S_RST_GAP: begin
                if (tmr_done) begin
                    if (err_q != ERR_NONE) begin
                        state_d = S_FIN;
                    end else begin
                        idx_clr = 1'b1;
                        state_d = S_VRD;
                    end
                end
            end
            S_VRD: state_d = S_VCMP;
            S_VCMP: begin
                if (fl_rdata != expect_byte) begin
                    set_vfy = 1'b1;
                    state_d = S_FIN;
                end else if (idx_q == LAST_IDX) begin
                    state_d = S_FIN;
                end else begin
                    idx_inc = 1'b1;
                    state_d = S_VRD;
                end
            end
            S_FIN: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_q  <= 1'b0;
            base_q  <= '0;
            step_q  <= '0;
            idx_q   <= '0;
            first_q <= '0;
            err_q   <= ERR_NONE;
        end else begin
            if (take_start) begin
                prog_q <= op_prog;
                base_q <= bank_base;
                step_q <= '0;
                idx_q  <= '0;
                err_q  <= ERR_NONE;
            end
            if (step_inc) step_q <= step_q + 3'd1;
            if (step_clr) step_q <= '0;
            if (idx_inc)  idx_q  <= idx_q + 1'b1;
            if (idx_clr)  idx_q  <= '0;
            if (state_q == S_POLL_B) first_q <= fl_rdata;
            if (set_tmo) err_q <= ERR_TIMEOUT;
            if (set_vfy) err_q <= ERR_VERIFY;
        end
    end

    // outputs
    always_comb begin
        fl_addr  = base_q;
        fl_wdata = CMD_RESET;
        fl_we    = 1'b0;
        fl_re    = 1'b0;
        unique case (state_q)
            S_CMD: begin
                fl_addr  = tbl_addr;
                fl_wdata = tbl_data;
                fl_we    = 1'b1;
            end
            S_RST: begin
                fl_addr  = base_q;
                fl_wdata = CMD_RESET;
                fl_we    = 1'b1;
            end
            S_POLL_A, S_POLL_B: begin
                fl_addr = base_q;
                fl_re   = 1'b1;
            end
            S_VRD: begin
                fl_addr = base_q + ADDR_W'(idx_q);
                fl_re   = 1'b1;
            end
            default: begin
                fl_addr = base_q;
            end
        endcase
        busy     = (state_q != S_IDLE);
        done     = (state_q == S_FIN);
        err_code = err_q;
        src_addr = idx_q;
    end

endmodule

// File: rtl/fpg_checker.sv
module fpg_checker #(
    parameter int GAP_CYC = 125
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic [1:0] err_code,
    input logic       fl_we,
    input logic       fl_re
);

    localparam int CW = $clog2(GAP_CYC + 1);

    logic [CW-1:0] idle_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt <= CW'(GAP_CYC);
        end else if (fl_we) begin
            idle_cnt <= '0;
        end else if (idle_cnt != CW'(GAP_CYC)) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_we && fl_re));

    // R4
    write_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_we |-> (idle_cnt == CW'(GAP_CYC)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R9
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> $stable(err_code));

    // R9
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

endmodule

bind flash_bank_prog fpg_checker #(.GAP_CYC(GAP_CYC)) u_fpg_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .err_code (err_code),
    .fl_we    (fl_we),
    .fl_re    (fl_re)
);

// File: tb/test_flash_bank_prog.sv
`timescale 1ns/1ps
module test_flash_bank_prog;

    localparam int ADDR_W = 16;
    localparam int BANK   = 32;
    localparam int GAP    = 3;
    localparam int MAXP   = 6;
    localparam int IDX_W  = $clog2(BANK);
    localparam logic [ADDR_W-1:0] BASE1 = 16'h4000;
    localparam logic [ADDR_W-1:0] BASE2 = 16'h8000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              op_prog = 1'b0;
    logic [ADDR_W-1:0] bank_base = '0;
    logic              busy, done;
    logic [1:0]        err_code;
    logic [ADDR_W-1:0] fl_addr;
    logic [7:0]        fl_wdata;
    logic              fl_we, fl_re;
    logic [7:0]        fl_rdata = 8'h00;
    logic [IDX_W-1:0]  src_addr;
    logic [7:0]        src_data;

    always #4 clk = ~clk;

    flash_bank_prog #(.ADDR_W(ADDR_W), .BANK_BYTES(BANK), .GAP_CYC(GAP), .MAX_POLLS(MAXP)) i_flash_bank_prog (
        .clk(clk), .rst_n(rst_n), .start(start), .op_prog(op_prog), .bank_base(bank_base),
        .busy(busy), .done(done), .err_code(err_code),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re), .fl_rdata(fl_rdata),
        .src_addr(src_addr), .src_data(src_data)
    );

    int errors = 0;
    int checks = 0;

    function automatic logic [7:0] pat_a(int i);
        return 8'(i * 29 + 60);
    endfunction

    logic pat_inv = 1'b0;
    assign src_data = pat_inv ? ~pat_a(int'(src_addr)) : pat_a(int'(src_addr));

    task automatic check(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // flash stub state
    logic [7:0]        mem [BANK];
    logic [ADDR_W-1:0] cur_base = '0;
    logic [7:0]        pend = 8'h00;
    logic              arm = 1'b0;
    logic              tog = 1'b0;
    int                busy_left = 0;
    logic              hang = 1'b0;
    logic              hung = 1'b0;
    int                stuck_cell = -1;
    int                base_reads = 0;
    int                since_we = 1000;
    int                min_gap = 1000;
    int                overlap = 0;
    int                done_cnt = 0;
    int                cyc = 0;
    logic              wd_fired = 1'b0;

    logic [ADDR_W+7:0] exp_w [$];
    logic [1:0]        exp_r [$];

    // stub and monitor, sampled away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) wd_fired = 1'b1;
        fl_rdata = pend;
        if (rst_n) begin
            if (fl_we && fl_re) overlap++;
            if (fl_re) begin
                int off;
                off = int'(fl_addr - cur_base);
                if (fl_addr == cur_base) base_reads++;
                if (busy_left > 0 || hung) begin
                    tog = ~tog;
                    pend = tog ? 8'h40 : 8'h00;
                    if (!hung) busy_left--;
                end else if (off >= 0 && off < BANK) begin
                    pend = mem[off];
                end else begin
                    pend = 8'h00;
                end
            end
            if (fl_we) begin
                int off;
                if (since_we < min_gap) min_gap = since_we;
                since_we = 0;
                if (exp_w.size() == 0) begin
                    check("R1", int'({fl_addr, fl_wdata}), 0, "unexpected bus write");
                end else begin
                    logic [ADDR_W+7:0] e;
                    e = exp_w.pop_front();
                    check("R3", int'({fl_addr, fl_wdata}), int'(e), "bus write {addr,data}");
                end
                off = int'(fl_addr - cur_base);
                if (arm) begin
                    arm = 1'b0;
                    if (off >= 0 && off < BANK) mem[off] = mem[off] & fl_wdata;
                    busy_left = 3;
                    if (hang) hung = 1'b1;
                end else if (fl_wdata == 8'hA0 && fl_addr == cur_base + 16'h555) begin
                    arm = 1'b1;
                end else if (fl_wdata == 8'h30 && fl_addr == cur_base) begin
                    for (int k = 0; k < BANK; k++) mem[k] = (k == stuck_cell) ? 8'h00 : 8'hFF;
                    busy_left = 3;
                    if (hang) hung = 1'b1;
                end
            end else begin
                since_we++;
            end
            if (done) begin
                done_cnt++;
                if (exp_r.size() == 0) begin
                    check("R9", 1, 0, "done without pending operation");
                end else begin
                    logic [1:0] e;
                    e = exp_r.pop_front();
                    check("R8", int'(err_code), int'(e), "err_code at done");
                end
            end
        end
    end

    function automatic logic [ADDR_W+7:0] wr(logic [ADDR_W-1:0] a, logic [7:0] d);
        return {a, d};
    endfunction

    task automatic push_unlock(logic [ADDR_W-1:0] b);
        exp_w.push_back(wr(b + 16'h555, 8'hAA));
        exp_w.push_back(wr(b + 16'h2AA, 8'h55));
    endtask

    // driver: pushes the expected writes and result, then starts the operation
    task automatic run_op(logic prog, logic [ADDR_W-1:0] b, logic [1:0] res,
                          int nbytes, logic poke);
        int target;
        cur_base = b;
        if (!prog) begin
            push_unlock(b);
            exp_w.push_back(wr(b + 16'h555, 8'h80));
            exp_w.push_back(wr(b + 16'h555, 8'hAA));
            exp_w.push_back(wr(b + 16'h2AA, 8'h55));
            exp_w.push_back(wr(b, 8'h30));
        end else begin
            for (int i = 0; i < nbytes; i++) begin
                push_unlock(b);
                exp_w.push_back(wr(b + 16'h555, 8'hA0));
                exp_w.push_back(wr(b + ADDR_W'(i), pat_inv ? ~pat_a(i) : pat_a(i)));
            end
        end
        exp_w.push_back(wr(b, 8'hF0));
        exp_r.push_back(res);
        target = done_cnt + 1;
        @(negedge clk);
        op_prog = prog;
        bank_base = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        op_prog = 1'b0;
        bank_base = 16'h0000;
        if (poke) begin
            repeat (10) @(negedge clk);
            check("R9", int'(busy), 1, "busy before overlapping start");
            op_prog = 1'b1;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            op_prog = 1'b0;
        end
        while (done_cnt < target && !wd_fired) @(negedge clk);
        repeat (3) @(negedge clk);
        check("R9", done_cnt, target, "done pulses");
        check("R7", exp_w.size(), 0, "writes left unissued");
    endtask

    task automatic check_mem(string req, logic inv);
        int bad = 0;
        for (int k = 0; k < BANK; k++) begin
            if (mem[k] != (inv ? 8'hFF : pat_a(k))) bad++;
        end
        check(req, bad, 0, "bank bytes differing from expected");
    endtask

    initial begin
        for (int k = 0; k < BANK; k++) mem[k] = 8'h00;
        repeat (4) @(negedge clk);
        // R10 reset state
        check("R10", int'(busy), 0, "busy after reset");
        check("R10", int'(done), 0, "done after reset");
        check("R10", int'(err_code), 0, "err_code after reset");
        check("R10", int'(fl_we), 0, "fl_we after reset");
        check("R10", int'(fl_re), 0, "fl_re after reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 R5 R7 erase completes after toggling stops
        run_op(1'b0, BASE1, 2'd0, 0, 1'b0);
        check_mem("R2", 1'b1);

        // R3 R8 program pattern
        run_op(1'b1, BASE1, 2'd0, BANK, 1'b0);
        check_mem("R3", 1'b0);

        // R8 program over non-blank bank fails verify
        pat_inv = 1'b1;
        run_op(1'b1, BASE1, 2'd2, BANK, 1'b0);
        pat_inv = 1'b0;

        // R8 erase with a cell that will not erase
        stuck_cell = 5;
        run_op(1'b0, BASE1, 2'd2, 0, 1'b0);
        stuck_cell = -1;

        // R6 erase timeout: exact number of polling reads, no verify
        hang = 1'b1;
        base_reads = 0;
        run_op(1'b0, BASE1, 2'd1, 0, 1'b0);
        check("R6", base_reads, 2 * MAXP, "base reads during timed-out erase");
        hang = 1'b0;
        hung = 1'b0;
        busy_left = 0;

        // R1 R9 erase at another base, overlapping start ignored
        run_op(1'b0, BASE2, 2'd0, 0, 1'b1);
        check_mem("R1", 1'b1);

        // R6 program timeout stops after first byte
        hang = 1'b1;
        run_op(1'b1, BASE2, 2'd1, 1, 1'b0);
        hang = 1'b0;
        hung = 1'b0;
        busy_left = 0;
        check("R9", int'(err_code), 1, "err_code held after done");

        check("R4", (min_gap >= GAP) ? 1 : 0, 1, "minimum idle cycles between writes");
        check("R10", overlap, 0, "cycles with both strobes");
        if (wd_fired) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=expired expected=finished");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule